// File: doc/BRIEF.md
# Pipelined Table-Based Radix-2 Butterfly

This block performs one radix-2 decimation-in-time butterfly step on complex fixed-point samples. A pair of complex inputs, X and Y, enters together under a single valid strobe. The block then returns the pair A = X + W·Y and B = X − W·Y a fixed number of cycles later, again under a valid strobe. The twiddle factor W is fixed at build time through parameters.

No hardware multiplier is used. Each Y component is cut into small digits. Every digit selects a precomputed entry from a constant table that holds the twiddle coefficient times that digit, already shifted to the digit's weight. The entries are registered and then summed into the real and imaginary products. X travels through a delay line of matching length. X is then sign-extended and shifted left by the twiddle's fraction width so that it lines up with the product. The final sum and difference come from Kogge-Stone prefix adders. The difference uses the same adder structure with the second operand inverted and a carry-in of one.

The block is meant for a stage of a larger transform in which one twiddle applies to every sample pair fed through it. It accepts a new pair on every clock cycle.

Top module: `bfly_r2_dsm`

## Requirements
- R1: Inputs are DW-bit two's-complement integers (default 8). The twiddle is the pair of signed integers (WR, WI), scaled by 2^FRAC (defaults 45, −45, FRAC = 6). The real and imaginary parts of output A equal exactly X·2^FRAC + W·Y: a_re = x_re·2^FRAC + WR·y_re − WI·y_im and a_im = x_im·2^FRAC + WR·y_im + WI·y_re.
- R2: The real and imaginary parts of output B equal exactly X·2^FRAC − W·Y, computed with the same products as in R1.
- R3: out_valid is high exactly three cycles after a cycle in which in_valid was high. It is low three cycles after a cycle in which in_valid was low, whatever data was present in that cycle.
- R4: A new input pair is accepted on every cycle. Back-to-back inputs produce back-to-back results in the same order.
- R5: A synchronous active-high reset drives out_valid and all four outputs to zero at the next edge and discards any pair still in flight.
- R6: The outputs are DW+CW+2 bits wide (default 18). They hold every result for the full input range, including −128 and 127 in every component, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the cycle's input pair as valid |
| x_re | input | DW | Real part of X, signed |
| x_im | input | DW | Imaginary part of X, signed |
| y_re | input | DW | Real part of Y, signed |
| y_im | input | DW | Imaginary part of Y, signed |
| out_valid | output | 1 | Marks the cycle's result pair as valid |
| a_re | output | DW+CW+2 | Real part of X·2^FRAC + W·Y, signed |
| a_im | output | DW+CW+2 | Imaginary part of X·2^FRAC + W·Y, signed |
| b_re | output | DW+CW+2 | Real part of X·2^FRAC − W·Y, signed |
| b_im | output | DW+CW+2 | Imaginary part of X·2^FRAC − W·Y, signed |

## Verification
The assertions assume that the inputs hold the pair in the same cycle in which in_valid is high. They also assume that no reset arrives between the moment a pair enters and the moment its result is checked; an attempt that overlaps a reset is abandoned. The stimulus drives every input on the falling edge. It only raises reset while in_valid is low. It then flushes its expected queue, so no result straddles a reset. Idle cycles carry random data on the inputs, which exercises the claim that unmarked data produces no result.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Register stages inside the constant multiplier: digit lookup, digit sum.
    localparam int MUL_LAT = 2;

    // Selects whether a prefix adder instance adds or subtracts.
    typedef enum logic {
        OP_SUM  = 1'b0,
        OP_DIFF = 1'b1
    } pfx_op_e;

    // Table entry: coefficient times a digit code, shifted to the digit weight.
    // The most significant digit is read as two's complement.
    function automatic int slice_entry(int coef, int code, int dg, bit top, int shift);
        int dv;
        dv = (top && code >= (1 << (dg - 1))) ? code - (1 << dg) : code;
        return (coef * dv) * (1 << shift);
    endfunction

endpackage

// File: rtl/pfx_addsub.sv
module pfx_addsub
    import bfly_pkg::*;
#(
    parameter int      N  = 18,
    parameter pfx_op_e OP = OP_SUM
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s
);
    localparam int   L   = $clog2(N);
    localparam logic CIN = (OP == OP_DIFF);

    logic [N-1:0] bb;
    logic [N-1:0] g0;
    logic [N-1:0] p0;

    assign bb = (OP == OP_DIFF) ? ~b : b;
    assign p0 = a ^ bb;

    always_comb begin
        g0    = a & bb;
        g0[0] = g0[0] | (p0[0] & CIN);
    end

    // Kogge-Stone tree: level lv merges spans 2^(lv-1) apart.
    for (genvar lv = 0; lv <= L; lv++) begin : g_lv
        logic [N-1:0] gg;
        logic [N-1:0] pp;
        if (lv == 0) begin : g_base
            assign gg = g0;
            assign pp = p0;
        end else begin : g_merge
            localparam int D = 1 << (lv - 1);
            for (genvar i = 0; i < N; i++) begin : g_bit
                if (i >= D) begin : g_op
                    assign g_lv[lv].gg[i] = g_lv[lv-1].gg[i] | (g_lv[lv-1].pp[i] & g_lv[lv-1].gg[i-D]);
                    assign g_lv[lv].pp[i] = g_lv[lv-1].pp[i] & g_lv[lv-1].pp[i-D];
                end else begin : g_pass
                    assign g_lv[lv].gg[i] = g_lv[lv-1].gg[i];
                    assign g_lv[lv].pp[i] = g_lv[lv-1].pp[i];
                end
            end
        end
    end

    logic unused_top;
    assign unused_top = ^g_lv[L].pp ^ g_lv[L].gg[N-1];

    assign s = p0 ^ {g_lv[L].gg[N-2:0], CIN};

endmodule

// File: rtl/dsm_cmac.sv
// Two-constant, two-operand product C0*a + C1*b from digit tables.
module dsm_cmac
    import bfly_pkg::*;
#(
    parameter int DW = 8,
    parameter int DG = 4,
    parameter int SW = 17,
    parameter int C0 = 0,
    parameter int C1 = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [SW-1:0] p
);
    localparam int ND = DW / DG;
    localparam int NV = 1 << DG;
    localparam int NP = 2 * ND;

    logic signed [SW-1:0] part_d [NP];
    logic signed [SW-1:0] part_q [NP];
    logic signed [SW-1:0] sum_d;

    for (genvar k = 0; k < ND; k++) begin : g_dig
        logic signed [SW-1:0] tab_a [NV];
        logic signed [SW-1:0] tab_b [NV];
        for (genvar v = 0; v < NV; v++) begin : g_ent
            assign tab_a[v] = SW'(slice_entry(C0, v, DG, (k == ND - 1), k * DG));
            assign tab_b[v] = SW'(slice_entry(C1, v, DG, (k == ND - 1), k * DG));
        end
        assign part_d[k]      = tab_a[a[k*DG +: DG]];
        assign part_d[ND + k] = tab_b[b[k*DG +: DG]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) part_q[i] <= '0;
        end else begin
            for (int i = 0; i < NP; i++) part_q[i] <= part_d[i];
        end
    end

    always_comb begin
        sum_d = '0;
        for (int i = 0; i < NP; i++) sum_d = sum_d + part_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) p <= '0;
        else     p <= sum_d;
    end

endmodule

// File: rtl/bfly_r2_dsm.sv
module bfly_r2_dsm
    import bfly_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DG   = 4,
    parameter int CW   = 8,
    parameter int FRAC = 6,
    parameter int WR   = 45,
    parameter int WI   = -45,
    localparam int SW  = DW + CW + 1,
    localparam int OW  = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    output logic                 out_valid,
    output logic signed [OW-1:0] a_re,
    output logic signed [OW-1:0] a_im,
    output logic signed [OW-1:0] b_re,
    output logic signed [OW-1:0] b_im
);
    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    cplx_t                x_pipe [MUL_LAT];
    logic [MUL_LAT-1:0]   vld_sr;
    logic signed [SW-1:0] prod_re;
    logic signed [SW-1:0] prod_im;
    logic signed [OW-1:0] xe [2];
    logic signed [OW-1:0] pe [2];
    logic [OW-1:0]        res [2][2];

    // X delay line and valid shift register, matched to the multiplier.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
            for (int i = 0; i < MUL_LAT; i++) x_pipe[i] <= '0;
        end else begin
            vld_sr    <= {vld_sr[MUL_LAT-2:0], in_valid};
            x_pipe[0] <= '{re: x_re, im: x_im};
            for (int i = 1; i < MUL_LAT; i++) x_pipe[i] <= x_pipe[i-1];
        end
    end

    // Re(W*Y) = WR*y_re - WI*y_im ; Im(W*Y) = WR*y_im + WI*y_re
    dsm_cmac #(.DW(DW), .DG(DG), .SW(SW), .C0(WR), .C1(-WI)) u_mul_re (
        .clk(clk), .rst(rst), .a(y_re), .b(y_im), .p(prod_re)
    );
    dsm_cmac #(.DW(DW), .DG(DG), .SW(SW), .C0(WR), .C1(WI)) u_mul_im (
        .clk(clk), .rst(rst), .a(y_im), .b(y_re), .p(prod_im)
    );

    assign xe[0] = OW'(x_pipe[MUL_LAT-1].re) <<< FRAC;
    assign xe[1] = OW'(x_pipe[MUL_LAT-1].im) <<< FRAC;
    assign pe[0] = OW'(prod_re);
    assign pe[1] = OW'(prod_im);

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        for (genvar op = 0; op < 2; op++) begin : g_op
            pfx_addsub #(.N(OW), .OP(pfx_op_e'(op))) u_as (
                .a(xe[ln]), .b(pe[ln]), .s(res[ln][op])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            a_re      <= '0;
            a_im      <= '0;
            b_re      <= '0;
            b_im      <= '0;
        end else begin
            out_valid <= vld_sr[MUL_LAT-1];
            a_re      <= signed'(res[0][0]);
            a_im      <= signed'(res[1][0]);
            b_re      <= signed'(res[0][1]);
            b_im      <= signed'(res[1][1]);
        end
    end

endmodule

// File: rtl/bfly_r2_dsm_chk.sv
module bfly_r2_dsm_chk
    import bfly_pkg::*;
#(
    parameter int DW   = 8,
    parameter int FRAC = 6,
    parameter int WR   = 45,
    parameter int WI   = -45,
    parameter int OW   = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] x_re,
    input logic signed [DW-1:0] x_im,
    input logic signed [DW-1:0] y_re,
    input logic signed [DW-1:0] y_im,
    input logic                 out_valid,
    input logic signed [OW-1:0] a_re,
    input logic signed [OW-1:0] a_im,
    input logic signed [OW-1:0] b_re,
    input logic signed [OW-1:0] b_im
);
    localparam int LAT = MUL_LAT + 1;

    // R3
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT out_valid);

    // R3
    idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##LAT !out_valid);

    // R1
    sum_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT
            ((int'(a_re) + int'(b_re)) == 2 * int'($past(x_re, LAT)) * (1 << FRAC)) &&
            ((int'(a_im) + int'(b_im)) == 2 * int'($past(x_im, LAT)) * (1 << FRAC)));

    // R2
    diff_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT
            ((int'(a_re) - int'(b_re)) ==
                2 * (WR * int'($past(y_re, LAT)) - WI * int'($past(y_im, LAT)))) &&
            ((int'(a_im) - int'(b_im)) ==
                2 * (WR * int'($past(y_im, LAT)) + WI * int'($past(y_re, LAT)))));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && a_re == 0 && a_im == 0 && b_re == 0 && b_im == 0));

endmodule

bind bfly_r2_dsm bfly_r2_dsm_chk #(
    .DW(DW), .FRAC(FRAC), .WR(WR), .WI(WI), .OW(OW)
) u_chk (.*);

// File: tb/bfly_r2_dsm_tb.sv
module bfly_r2_dsm_tb;
    localparam int DW   = 8;
    localparam int FRAC = 6;
    localparam int WR   = 45;
    localparam int WI   = -45;
    localparam int OW   = 18;
    localparam int LAT  = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic                 out_valid;
    logic signed [OW-1:0] a_re, a_im, b_re, b_im;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int    are, aim, bre, bim;
        int    issue;
        string tag;
    } exp_t;

    exp_t sbq[$];

    bfly_r2_dsm #(.DW(DW), .FRAC(FRAC), .WR(WR), .WI(WI)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .out_valid(out_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int got, int expv);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic send(int xr, int xi, int yr, int yi, string tag);
        exp_t e;
        @(negedge clk);
        x_re = DW'(xr); x_im = DW'(xi); y_re = DW'(yr); y_im = DW'(yi);
        in_valid = 1'b1;
        e.are   = xr * (1 << FRAC) + (WR * yr - WI * yi);
        e.aim   = xi * (1 << FRAC) + (WR * yi + WI * yr);
        e.bre   = xr * (1 << FRAC) - (WR * yr - WI * yi);
        e.bim   = xi * (1 << FRAC) - (WR * yi + WI * yr);
        e.issue = cyc;
        e.tag   = tag;
        sbq.push_back(e);
    endtask

    // R3: idle cycles carry random data that must produce nothing
    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            x_re = DW'($urandom); x_im = DW'($urandom);
            y_re = DW'($urandom); y_im = DW'($urandom);
        end
    endtask

    task automatic chk_cleared(string what);
        chk("R5", {what, " out_valid"}, int'(out_valid), 0);
        chk("R5", {what, " a_re"}, int'(a_re), 0);
        chk("R5", {what, " b_im"}, int'(b_im), 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R3 unexpected out_valid: got 1 expected 0");
            end else begin
                e = sbq.pop_front();
                chk("R3", {"latency ", e.tag}, cyc - e.issue, LAT);
                chk("R1", {"a_re ", e.tag}, int'(a_re), e.are);
                chk("R1", {"a_im ", e.tag}, int'(a_im), e.aim);
                chk("R2", {"b_re ", e.tag}, int'(b_re), e.bre);
                chk("R2", {"b_im ", e.tag}, int'(b_im), e.bim);
            end
        end
    end

    localparam int CORN [4] = '{-128, 127, 0, -1};

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_cleared("in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_cleared("after reset");

        // R1 R2: simple hand patterns
        send(1, 0, 0, 0, "x only");
        send(0, 0, 1, 0, "y re");
        send(0, 0, 0, 1, "y im");
        send(-5, 7, 3, -9, "mixed");
        idle(4);

        // R6: full-range corners in every component
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 4; k++)
                    for (int m = 0; m < 4; m++)
                        send(CORN[i], CORN[j], CORN[k], CORN[m], "R6 corner");
        idle(5);

        // R4: back-to-back burst
        for (int i = 0; i < 20; i++)
            send(i * 11 - 100, 90 - i * 9, i * 13 - 128, 127 - i * 12, "R4 burst");
        idle(5);

        // R5: reset with pairs in flight discards them
        send(10, 20, 30, 40, "pre-reset");
        send(50, 60, 70, 80, "pre-reset");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sbq.delete();
        repeat (2) @(negedge clk);
        chk_cleared("mid reset");
        rst = 1'b0;
        idle(5);
        chk("R5", "flushed pairs produced no output", sbq.size(), 0);

        // R1 R2 R3: random pairs with random gaps
        for (int i = 0; i < 400; i++) begin
            send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                 $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128, "random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(6);
        chk("R4", "all results delivered", sbq.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule